// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block sits behind an I2C slave bit shifter and decides, one received byte at a time, whether the device is being addressed with a 10-bit address. A Start or Restart makes the next byte an address byte. That first byte carries the fixed prefix 11110, the two upper address bits and the direction bit. For a write, a second byte carries the lower eight address bits. Each address byte gets an acknowledge decision one cycle after it is presented.

After a complete write match, the block keeps a remembered-match flag. A later Restart followed by the first address byte with the read bit set then selects slave transmit without the lower byte being sent again. On that selection the block asks for the serial clock to be held low, so that transmit data can be loaded. A release pulse ends the hold. A Stop, a mismatching first byte, or a first byte with the write bit drops the remembered match.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, ack_valid, ack, matched, is_read and clk_hold are all 0.
- R2: A byte presented as the first address byte after Start or Restart gives ack_valid=1 one cycle later. With the write bit (bit 0 = 0), ack=1 exactly when bits 7:3 are 11110 and bits 2:1 equal own_addr[9:8].
- R3: The byte after an acknowledged write first byte is acknowledged exactly when it equals own_addr[7:0]. In that case matched=1 and is_read=0 from the next cycle on.
- R4: A first byte with the read bit (bit 0 = 1) and no remembered match is not acknowledged, and matched stays 0.
- R5: After a full write match and a Restart, a matching first byte with the read bit gets ack=1 and sets matched=1, is_read=1 and clk_hold=1. This repeats on each further Restart until the remembered match is cleared.
- R6: A Stop clears matched, is_read, clk_hold and the remembered match, and bytes that follow it are ignored until the next Start.
- R7: A first address byte that fails to match clears the remembered match.
- R8: A matching first address byte with the write bit clears the remembered match, so a later read first byte needs a new low-byte match.
- R9: A Start or Restart clears matched and is_read. Bytes received in the data phase, or after a refused address byte, give no ack_valid.
- R10: A hold_release pulse drops clk_hold in the next cycle and leaves matched and is_read unchanged.
- R11: A Stop in the same cycle as a Start or Restart acts as a Stop alone. A byte presented in the same cycle as a Start or Restart is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| start_det | input | 1 | Start condition strobe |
| restart_det | input | 1 | Repeated Start strobe |
| stop_det | input | 1 | Stop condition strobe |
| own_addr | input | 10 | Programmed 10-bit slave address |
| hold_release | input | 1 | Pulse: transmit data loaded, release the clock |
| ack_valid | output | 1 | Pulse: ack holds the decision for the last address byte |
| ack | output | 1 | 1 = acknowledge the address byte |
| matched | output | 1 | Device fully addressed in this transfer |
| is_read | output | 1 | 1 = slave transmit selected |
| clk_hold | output | 1 | Request to hold the serial clock low |

## Verification
The assertions check on every cycle the rules that hold whatever came before. An acknowledge pulse always follows a byte. A hold request only exists while a read is selected. A read only starts from a remembered match. A Stop or Start always leaves the matched and direction state cleared, and a release always drops the hold. What only the bench can show is the sequence rules that depend on history. These are the exact accept set over every possible first and second byte, the remembered match surviving Restarts, and each of the three ways it is lost. Strobe priority when events coincide also needs the bench.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int PFX_W  = 5;
  localparam logic [PFX_W-1:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_LOW  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  // prefix field of the first address byte
  function automatic logic hdr_prefix_ok(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: PFX_W] == HDR_PREFIX;
  endfunction

  // upper address bits sit between prefix and direction bit
  function automatic logic hdr_upper_ok(input logic [BYTE_W-1:0] b,
                                        input logic [ADDR_W-BYTE_W-1:0] hi);
    return b[ADDR_W-BYTE_W:1] == hi;
  endfunction

endpackage

// File: rtl/i2c10_hdr_decode.sv
module i2c10_hdr_decode
  import i2c10_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic [BW-1:0] byte_data,
  input  logic [AW-1:0] own_addr,
  output logic          hdr_ok,
  output logic          hdr_rw,
  output logic          low_ok
);
  localparam int HI_W = AW - BW;

  logic [HI_W-1:0] own_hi;
  logic [BW-1:0]   own_lo;

  assign own_hi = own_addr[AW-1:BW];
  assign own_lo = own_addr[BW-1:0];

  always_comb begin
    hdr_ok = hdr_prefix_ok(byte_data) && hdr_upper_ok(byte_data, own_hi);
    hdr_rw = byte_data[0];
    low_ok = (byte_data == own_lo);
  end
endmodule

// File: rtl/i2c10_addr_fsm.sv
module i2c10_addr_fsm
  import i2c10_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic start_det,
  input  logic restart_det,
  input  logic stop_det,
  input  logic hdr_ok,
  input  logic hdr_rw,
  input  logic low_ok,
  output logic ack_valid,
  output logic ack,
  output logic matched,
  output logic is_read,
  output logic prior_q,
  output logic ev_read_select,
  output logic ev_write_match,
  output logic ev_hdr_fail
);
  phase_t phase_q, phase_d;
  logic   prior_d, matched_d, read_d, ackv_d, ack_d;
  logic   strobe_any, byte_live;

  assign strobe_any = start_det | restart_det;
  assign byte_live  = byte_valid & ~stop_det & ~strobe_any;

  assign ev_read_select = byte_live && phase_q == PH_HDR && hdr_ok && hdr_rw && prior_q;
  assign ev_write_match = byte_live && phase_q == PH_LOW && low_ok;
  assign ev_hdr_fail    = byte_live && phase_q == PH_HDR && !hdr_ok;

  always_comb begin
    phase_d   = phase_q;
    prior_d   = prior_q;
    matched_d = matched;
    read_d    = is_read;
    ackv_d    = 1'b0;
    ack_d     = 1'b0;
    if (stop_det) begin
      phase_d   = PH_IDLE;
      prior_d   = 1'b0;
      matched_d = 1'b0;
      read_d    = 1'b0;
    end else if (strobe_any) begin
      phase_d   = PH_HDR;
      matched_d = 1'b0;
      read_d    = 1'b0;
    end else if (byte_valid) begin
      unique case (phase_q)
        PH_HDR: begin
          ackv_d = 1'b1;
          if (!hdr_ok) begin
            prior_d = 1'b0;
            phase_d = PH_IDLE;
          end else if (!hdr_rw) begin
            ack_d   = 1'b1;
            prior_d = 1'b0;
            phase_d = PH_LOW;
          end else if (prior_q) begin
            ack_d     = 1'b1;
            matched_d = 1'b1;
            read_d    = 1'b1;
            phase_d   = PH_DATA;
          end else begin
            phase_d = PH_IDLE;
          end
        end
        PH_LOW: begin
          ackv_d = 1'b1;
          if (low_ok) begin
            ack_d     = 1'b1;
            matched_d = 1'b1;
            read_d    = 1'b0;
            prior_d   = 1'b1;
            phase_d   = PH_DATA;
          end else begin
            phase_d = PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      prior_q   <= 1'b0;
      matched   <= 1'b0;
      is_read   <= 1'b0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      prior_q   <= prior_d;
      matched   <= matched_d;
      is_read   <= read_d;
      ack_valid <= ackv_d;
      ack       <= ack_d;
    end
  end
endmodule

// File: rtl/i2c10_hold_ctl.sv
module i2c10_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_set,
  input  logic hold_clr,
  output logic clk_hold
);
  // a new read selection wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clk_hold <= 1'b0;
    else if (hold_set) clk_hold <= 1'b1;
    else if (hold_clr) clk_hold <= 1'b0;
  end
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_data,
  input  logic          start_det,
  input  logic          restart_det,
  input  logic          stop_det,
  input  logic [AW-1:0] own_addr,
  input  logic          hold_release,
  output logic          ack_valid,
  output logic          ack,
  output logic          matched,
  output logic          is_read,
  output logic          clk_hold
);
  logic hdr_ok, hdr_rw, low_ok;
  logic prior_q, ev_read_select, ev_write_match, ev_hdr_fail;
  logic hold_clr;

  i2c10_hdr_decode #(.BW(BW), .AW(AW)) u_dec (
    .byte_data (byte_data),
    .own_addr  (own_addr),
    .hdr_ok    (hdr_ok),
    .hdr_rw    (hdr_rw),
    .low_ok    (low_ok)
  );

  i2c10_addr_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .start_det      (start_det),
    .restart_det    (restart_det),
    .stop_det       (stop_det),
    .hdr_ok         (hdr_ok),
    .hdr_rw         (hdr_rw),
    .low_ok         (low_ok),
    .ack_valid      (ack_valid),
    .ack            (ack),
    .matched        (matched),
    .is_read        (is_read),
    .prior_q        (prior_q),
    .ev_read_select (ev_read_select),
    .ev_write_match (ev_write_match),
    .ev_hdr_fail    (ev_hdr_fail)
  );

  assign hold_clr = hold_release | stop_det | start_det | restart_det;

  i2c10_hold_ctl u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_set (ev_read_select),
    .hold_clr (hold_clr),
    .clk_hold (clk_hold)
  );
endmodule

// File: rtl/i2c10_addr_chk.sv
module i2c10_addr_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic start_det,
  input logic restart_det,
  input logic stop_det,
  input logic hold_release,
  input logic ack_valid,
  input logic ack,
  input logic matched,
  input logic is_read,
  input logic clk_hold,
  input logic prior_q,
  input logic ev_read_select,
  input logic ev_write_match,
  input logic ev_hdr_fail
);
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid));

  p_ack_only_decided_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_valid);

  p_match_is_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched) |-> ack_valid && ack);

  p_read_needs_prior_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_read) |-> $past(prior_q));

  p_hold_with_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |-> is_read && matched);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !matched && !is_read && !clk_hold && !prior_q);

  p_fail_drops_prior_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_fail |=> !prior_q);

  p_write_match_sets_prior_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_match |=> prior_q && matched && !is_read);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det || restart_det) |-> !matched && !is_read);

  p_release_drops_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_release) && !$past(ev_read_select)) |-> !clk_hold);
endmodule

bind i2c10_addr_match i2c10_addr_chk u_chk (.*);

// File: tb/sim_i2c10_addr_match.sv
`timescale 1ns/1ps
module sim_i2c10_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       start_det = 1'b0, restart_det = 1'b0, stop_det = 1'b0;
  logic [9:0] own = 10'h2A5;
  logic       hold_release = 1'b0;
  logic       ack_valid, ack, matched, is_read, clk_hold;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2c10_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .start_det(start_det), .restart_det(restart_det), .stop_det(stop_det),
    .own_addr(own), .hold_release(hold_release), .ack_valid(ack_valid),
    .ack(ack), .matched(matched), .is_read(is_read), .clk_hold(clk_hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // each strobe is driven at a falling edge and the outputs are read one cycle later
  task automatic strobe(input logic s, input logic rs, input logic p);
    @(negedge clk); start_det = s; restart_det = rs; stop_det = p;
    @(negedge clk); start_det = 0; restart_det = 0; stop_det = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1; byte_data = b;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic release_hold();
    @(negedge clk); hold_release = 1;
    @(negedge clk); hold_release = 0;
  endtask

  function automatic logic [7:0] hi(input logic rw);
    return {5'b11110, own[9:8], rw};
  endfunction

  task automatic full_write();
    strobe(0, 0, 1); strobe(1, 0, 0);
    send(hi(1'b0)); send(own[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack_valid", ack_valid, 0); check("R1 ack", ack, 0);
    check("R1 matched", matched, 0); check("R1 is_read", is_read, 0);
    check("R1 clk_hold", clk_hold, 0);
    rst_n = 1;

    for (int k = 0; k < 2; k++) begin
      own = (k == 0) ? 10'h2A5 : 10'h15A;
      // every possible first address byte, from a clean bus
      for (int b = 0; b < 256; b++) begin
        logic [7:0] bb; logic exp;
        bb = 8'(b);
        exp = (bb[7:3] == 5'b11110) && (bb[2:1] == own[9:8]) && !bb[0];
        strobe(0, 0, 1); strobe(1, 0, 0); send(bb);
        check("R2 ack_valid", ack_valid, 1);
        check(bb[0] ? "R4 ack" : "R2 ack", ack, exp);
        check("R4 matched", matched, 0);
      end
      // every possible second address byte
      for (int v = 0; v < 256; v++) begin
        logic exp;
        exp = (8'(v) == own[7:0]);
        strobe(0, 0, 1); strobe(1, 0, 0); send(hi(1'b0)); send(8'(v));
        check("R3 ack", ack, exp);
        check("R3 matched", matched, exp);
        check("R3 is_read", is_read, 0);
      end
    end

    // refused address: later bytes ignored
    strobe(0, 0, 1); strobe(1, 0, 0); send(8'h00);
    send(hi(1'b0));
    check("R9 after refusal", ack_valid, 0);

    // data phase and restart clearing
    full_write();
    send(hi(1'b0));
    check("R9 data byte", ack_valid, 0);
    check("R9 still matched", matched, 1);
    strobe(0, 1, 0);
    check("R9 restart clears matched", matched, 0);

    // read through remembered match
    send(hi(1'b1));
    check("R5 ack", ack, 1); check("R5 matched", matched, 1);
    check("R5 is_read", is_read, 1); check("R5 clk_hold", clk_hold, 1);
    release_hold();
    check("R10 hold released", clk_hold, 0);
    check("R10 matched kept", matched, 1);
    check("R10 is_read kept", is_read, 1);
    strobe(0, 1, 0); send(hi(1'b1));
    check("R5 repeat ack", ack, 1); check("R5 repeat hold", clk_hold, 1);
    strobe(0, 0, 1);
    check("R6 hold", clk_hold, 0); check("R6 matched", matched, 0);
    check("R6 is_read", is_read, 0);
    send(hi(1'b0));
    check("R6 ignored after stop", ack_valid, 0);
    strobe(1, 0, 0); send(hi(1'b1));
    check("R6 prior gone", ack, 0);

    // mismatching first byte drops remembered match
    full_write(); strobe(0, 1, 0);
    send({5'b11110, ~own[9:8], 1'b0});
    check("R7 bad hdr nack", ack, 0);
    strobe(0, 1, 0); send(hi(1'b1));
    check("R7 prior gone", ack, 0);

    // write first byte drops remembered match
    full_write(); strobe(0, 1, 0); send(hi(1'b0));
    check("R8 write hdr ack", ack, 1);
    strobe(0, 1, 0); send(hi(1'b1));
    check("R8 prior gone", ack, 0);
    check("R8 matched", matched, 0);

    // coinciding events
    full_write(); strobe(0, 1, 1);
    check("R11 stop wins matched", matched, 0);
    strobe(0, 1, 0); send(hi(1'b1));
    check("R11 stop wins prior", ack, 0);
    @(negedge clk); start_det = 1; byte_valid = 1; byte_data = hi(1'b0);
    @(negedge clk); start_det = 0; byte_valid = 0;
    check("R11 byte with start ignored", ack_valid, 0);
    send(hi(1'b0));
    check("R11 next byte is header", ack, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule